// File: doc/BRIEF.md
# Bidirectional Cross-Clock Mailbox Pair

This block carries single 36-bit words between two independent clock domains, next to a FIFO data path. There are two mailboxes. Mailbox 1 is loaded from port A and read on port B. Mailbox 2 is loaded from port B and read on port A. Each mailbox has an active-low "mail waiting" flag. The block gives a view of that flag in each clock domain.

An access on a port counts only on a rising edge of that port's clock, with chip select low and enable high. A per-port mailbox-select input then sends the access either to the mailbox or to the FIFO path. On port B the same select also picks the read data: the mailbox-1 word, or the word that comes from the FIFO.

A write sets the flag in the writer's clock domain. A qualified read clears it in the reader's clock domain. Each event crosses to the other domain as a toggle through a two-flop synchronizer. A write to a mailbox whose flag is still low in the writer's view is dropped, so unread mail is never overwritten.

Top module: `mbx_pair`

## Requirements
- R1: A port acts only on a rising edge of its own clock with chip select low (0) and enable high (1). With chip select high or enable low, neither flag nor mailbox word changes.
- R2: A qualified port-A write (a_write=1) with a_mbx=1, while m1_flag_a_n is high, loads a_din into mailbox 1. m1_flag_a_n reads low directly after that clk_a edge.
- R3: After a mailbox-1 write, m1_flag_b_n goes low within three rising clk_b edges.
- R4: A qualified port-B read (b_write=0) with b_mbx=1, while m1_flag_b_n is low, drives m1_flag_b_n high directly after that clk_b edge. m1_flag_a_n then returns high within three rising clk_a edges.
- R5: A mailbox write while the writer-side flag of that mailbox is low is ignored, and the stored word keeps its value.
- R6: Mailbox 2 mirrors mailbox 1 with the ports swapped:
  - A qualified port-B write with b_mbx=1 drives m2_flag_b_n low directly after the clk_b edge.
  - m2_flag_a_n goes low within three clk_a edges.
  - A qualified port-A read with a_mbx=1 drives m2_flag_a_n high directly after the clk_a edge.
  - m2_flag_b_n returns high within three clk_b edges.
- R7: While rst is high at the edges of both clocks, all four flags go high and both mailbox words go to zero.
- R8: b_dout equals mailbox 1 when b_mbx=1 and equals b_fifo_q when b_mbx=0.
- R9: a_dout always presents the word held in mailbox 2.
- R10: Accesses with the mailbox select low (FIFO path) change neither mailbox flag nor mailbox word.
- R11: A mailbox read while that mailbox's reader-side flag is high has no effect. The flag stays high, and the following write still sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port-A clock |
| clk_b | input | 1 | Port-B clock, unrelated to clk_a |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| a_cs_n | input | 1 | Port-A chip select, active low |
| a_en | input | 1 | Port-A enable, active high |
| a_write | input | 1 | Port-A direction: 1 write, 0 read |
| a_mbx | input | 1 | Port-A select: 1 mailbox, 0 FIFO path |
| a_din | input | 36 | Port-A write data |
| a_dout | output | 36 | Port-A read data (mailbox 2) |
| m1_flag_a_n | output | 1 | Mailbox-1 waiting flag, clk_a view, low = mail |
| m2_flag_a_n | output | 1 | Mailbox-2 waiting flag, clk_a view, low = mail |
| b_cs_n | input | 1 | Port-B chip select, active low |
| b_en | input | 1 | Port-B enable, active high |
| b_write | input | 1 | Port-B direction: 1 write, 0 read |
| b_mbx | input | 1 | Port-B select: 1 mailbox, 0 FIFO path |
| b_din | input | 36 | Port-B write data |
| b_fifo_q | input | 36 | Word from the FIFO output register |
| b_dout | output | 36 | Port-B read data, mailbox 1 or FIFO word |
| m1_flag_b_n | output | 1 | Mailbox-1 waiting flag, clk_b view, low = mail |
| m2_flag_b_n | output | 1 | Mailbox-2 waiting flag, clk_b view, low = mail |

## Verification
On every edge of its own domain, the assertions check these local rules:
- a write with the writer flag high sets that flag;
- a write with the writer flag low leaves the word stable;
- a reader-side read with mail pending clears the reader flag;
- a read with no mail pending leaves the reader flag high;
- an unqualified port-A cycle cannot set the mailbox-1 flag.

The cross-domain results can only be shown by the bench scenarios. These are the arrival of the flag in the far domain within the synchronizer delay, the delivery of the exact word, the port-B output selection, the reset values, and the FIFO-path accesses leaving both mailboxes untouched.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int MBX_DATA_W = 36;
    localparam int MBX_SYNC_STAGES = 2;

    typedef struct packed {
        logic mbx_wr;
        logic mbx_rd;
    } port_req_t;

    function automatic port_req_t decode_port(input logic cs_n, input logic en,
                                              input logic write, input logic mbx);
        port_req_t r;
        r.mbx_wr = !cs_n && en && write && mbx;
        r.mbx_rd = !cs_n && en && !write && mbx;
        return r;
    endfunction

endpackage

// File: rtl/mbx_tog_sync.sv
module mbx_tog_sync #(
    parameter int STAGES = mbx_pkg::MBX_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic tog_in,
    output logic tog_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], tog_in};
    end

    assign tog_out = chain[STAGES-1];
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int W = mbx_pkg::MBX_DATA_W
) (
    input  logic         clk_w,
    input  logic         clk_r,
    input  logic         rst,
    input  logic         wr_fire,
    input  logic [W-1:0] wr_data,
    input  logic         rd_fire,
    output logic [W-1:0] data_q,
    output logic         wr_flag_n,
    output logic         rd_flag_n
);
    logic w_tog, r_tog, r_tog_at_w, w_tog_at_r;

    // writer domain: load word and flip the set toggle
    always_ff @(posedge clk_w) begin
        if (rst) begin
            w_tog  <= 1'b0;
            data_q <= '0;
        end else if (wr_fire && wr_flag_n) begin
            w_tog  <= ~w_tog;
            data_q <= wr_data;
        end
    end

    mbx_tog_sync i_sync_r2w (.clk(clk_w), .rst(rst), .tog_in(r_tog), .tog_out(r_tog_at_w));
    assign wr_flag_n = ~(w_tog ^ r_tog_at_w);

    // reader domain: flip the clear toggle only when mail is pending
    always_ff @(posedge clk_r) begin
        if (rst)                        r_tog <= 1'b0;
        else if (rd_fire && !rd_flag_n) r_tog <= ~r_tog;
    end

    mbx_tog_sync i_sync_w2r (.clk(clk_r), .rst(rst), .tog_in(w_tog), .tog_out(w_tog_at_r));
    assign rd_flag_n = ~(w_tog_at_r ^ r_tog);

    assert_write_sets_flag_R2: assert property (@(posedge clk_w) disable iff (rst)
        (wr_fire && wr_flag_n) |=> !wr_flag_n);

    assert_full_write_ignored_R5: assert property (@(posedge clk_w) disable iff (rst)
        (!wr_flag_n) |=> $stable(data_q));

    assert_read_clears_flag_R4: assert property (@(posedge clk_r) disable iff (rst)
        (rd_fire && !rd_flag_n) |=> rd_flag_n);

    assert_empty_read_noop_R11: assert property (@(posedge clk_r) disable iff (rst)
        (rd_flag_n && !(w_tog_at_r ^ w_tog)) |=> rd_flag_n);
endmodule

// File: rtl/mbx_pair.sv
module mbx_pair
    import mbx_pkg::*;
#(
    parameter int W = MBX_DATA_W
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst,
    input  logic         a_cs_n,
    input  logic         a_en,
    input  logic         a_write,
    input  logic         a_mbx,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         m1_flag_a_n,
    output logic         m2_flag_a_n,
    input  logic         b_cs_n,
    input  logic         b_en,
    input  logic         b_write,
    input  logic         b_mbx,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_dout,
    output logic         m1_flag_b_n,
    output logic         m2_flag_b_n
);
    port_req_t req_a, req_b;
    logic [W-1:0] mail1_q, mail2_q;

    assign req_a = decode_port(a_cs_n, a_en, a_write, a_mbx);
    assign req_b = decode_port(b_cs_n, b_en, b_write, b_mbx);

    // mailbox 1: port A writes, port B reads
    mbx_slot #(.W(W)) i_mail1 (
        .clk_w(clk_a), .clk_r(clk_b), .rst(rst),
        .wr_fire(req_a.mbx_wr), .wr_data(a_din), .rd_fire(req_b.mbx_rd),
        .data_q(mail1_q), .wr_flag_n(m1_flag_a_n), .rd_flag_n(m1_flag_b_n)
    );

    // mailbox 2: port B writes, port A reads
    mbx_slot #(.W(W)) i_mail2 (
        .clk_w(clk_b), .clk_r(clk_a), .rst(rst),
        .wr_fire(req_b.mbx_wr), .wr_data(b_din), .rd_fire(req_a.mbx_rd),
        .data_q(mail2_q), .wr_flag_n(m2_flag_b_n), .rd_flag_n(m2_flag_a_n)
    );

    assign a_dout = mail2_q;
    assign b_dout = b_mbx ? mail1_q : b_fifo_q;

    assert_unqualified_no_set_R1: assert property (@(posedge clk_a) disable iff (rst)
        ((a_cs_n || !a_en) && m1_flag_a_n) |=> m1_flag_a_n);
endmodule

// File: tb/test_mbx_pair.sv
`timescale 1ns/100ps
module test_mbx_pair;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0, rst = 1'b1;
    logic a_cs_n = 1'b1, a_en = 1'b0, a_write = 1'b0, a_mbx = 1'b0;
    logic b_cs_n = 1'b1, b_en = 1'b0, b_write = 1'b0, b_mbx = 1'b0;
    logic [W-1:0] a_din = '0, b_din = '0, b_fifo_q = 36'hF1F0_0F1F0;
    logic [W-1:0] a_dout, b_dout;
    logic m1_flag_a_n, m2_flag_a_n, m1_flag_b_n, m2_flag_b_n;
    int checks = 0, failures = 0;
    bit finished = 1'b0;

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    mbx_pair #(.W(W)) i_mbx_pair (.*);

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic a_cycle(input logic cs_n, input logic en, input logic wr,
                           input logic mbx, input logic [W-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_write = wr; a_mbx = mbx; a_din = d;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0;
    endtask

    task automatic b_cycle(input logic cs_n, input logic en, input logic wr,
                           input logic mbx, input logic [W-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_write = wr; b_mbx = mbx; b_din = d;
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk_b);
        repeat (4) @(negedge clk_a);
    endtask

    task automatic t_reset();
        b_mbx = 1'b1;
        @(negedge clk_b);
        check("R7 m1_flag_a_n", m1_flag_a_n, 1);
        check("R7 m2_flag_a_n", m2_flag_a_n, 1);
        check("R7 m1_flag_b_n", m1_flag_b_n, 1);
        check("R7 m2_flag_b_n", m2_flag_b_n, 1);
        check("R7 a_dout", a_dout, 0);
        check("R7 b_dout", b_dout, 0);
    endtask

    task automatic t_mail1();
        a_cycle(0, 1, 1, 1, 36'hA_1234_5678);
        check("R2 m1_flag_a_n after write", m1_flag_a_n, 0);
        repeat (3) @(negedge clk_b);
        check("R3 m1_flag_b_n", m1_flag_b_n, 0);
        b_mbx = 1'b1; #0.1;
        check("R8 b_dout mailbox", b_dout, 36'hA_1234_5678);
        b_cycle(0, 1, 0, 1, '0);
        check("R4 m1_flag_b_n after read", m1_flag_b_n, 1);
        repeat (3) @(negedge clk_a);
        check("R4 m1_flag_a_n returns", m1_flag_a_n, 1);
    endtask

    task automatic t_overwrite();
        a_cycle(0, 1, 1, 1, 36'h1_1111_1111);
        a_cycle(0, 1, 1, 1, 36'h2_2222_2222);
        settle();
        b_mbx = 1'b1; #0.1;
        check("R5 second write ignored", b_dout, 36'h1_1111_1111);
        b_cycle(0, 1, 0, 1, '0);
        settle();
        check("R5 flag clear after read", m1_flag_a_n, 1);
    endtask

    task automatic t_qualify();
        a_cycle(0, 0, 1, 1, 36'h3_3333_3333);
        a_cycle(1, 1, 1, 1, 36'h4_4444_4444);
        settle();
        check("R1 unqualified A write flag", m1_flag_a_n, 1);
        b_mbx = 1'b1; #0.1;
        check("R1 unqualified A write data", b_dout, 36'h1_1111_1111);
        a_cycle(0, 1, 1, 1, 36'h5_5555_5555);
        settle();
        b_cycle(1, 1, 0, 1, '0);
        b_cycle(0, 0, 0, 1, '0);
        settle();
        check("R1 unqualified B read keeps flag", m1_flag_b_n, 0);
        b_cycle(0, 1, 0, 1, '0);
        settle();
    endtask

    task automatic t_fifo_path();
        a_cycle(0, 1, 1, 0, 36'h6_6666_6666);
        b_cycle(0, 1, 1, 0, 36'h7_7777_7777);
        settle();
        check("R10 A fifo write m1 flag", m1_flag_b_n, 1);
        check("R10 B fifo write m2 flag", m2_flag_a_n, 1);
        check("R10 B fifo write m2 data", a_dout, 0);
        b_mbx = 1'b0; #0.1;
        check("R8 b_dout fifo", b_dout, b_fifo_q);
        a_cycle(0, 1, 1, 1, 36'h8_8888_8888);
        settle();
        b_cycle(0, 1, 0, 0, '0);
        settle();
        check("R10 fifo read keeps m1 mail", m1_flag_b_n, 0);
        b_cycle(0, 1, 0, 1, '0);
        settle();
    endtask

    task automatic t_mail2();
        b_cycle(0, 1, 1, 1, 36'h9_ABCD_EF01);
        check("R6 m2_flag_b_n after write", m2_flag_b_n, 0);
        repeat (3) @(negedge clk_a);
        check("R6 m2_flag_a_n", m2_flag_a_n, 0);
        check("R9 a_dout", a_dout, 36'h9_ABCD_EF01);
        a_cycle(0, 1, 0, 1, '0);
        check("R6 m2_flag_a_n after read", m2_flag_a_n, 1);
        repeat (3) @(negedge clk_b);
        check("R6 m2_flag_b_n returns", m2_flag_b_n, 1);
    endtask

    task automatic t_empty_read();
        b_cycle(0, 1, 0, 1, '0);
        a_cycle(0, 1, 0, 1, '0);
        settle();
        check("R11 m1_flag_b_n stays", m1_flag_b_n, 1);
        check("R11 m1_flag_a_n stays", m1_flag_a_n, 1);
        check("R11 m2_flag_a_n stays", m2_flag_a_n, 1);
        a_cycle(0, 1, 1, 1, 36'hC_0FFE_E000);
        settle();
        check("R11 write after empty read", m1_flag_b_n, 0);
    endtask

    initial begin
        repeat (6) @(negedge clk_b);
        rst = 1'b0;
        t_reset();
        t_mail1();
        t_overwrite();
        t_qualify();
        t_fifo_path();
        t_mail2();
        t_empty_read();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule